// File: doc/BRIEF.md
# Serial ADC Interface Sequencer

This block is the digital side of a four-wire serial port on a successive-approximation converter. The whole block runs from one system clock. Every interface pin passes through a two-flop synchroniser, and serial clock edges are detected in the system domain. When chip select falls, the block latches whether the host is a microcontroller or a DSP. It then takes in a four-bit command and shifts out the previous ten-bit conversion result, with a separate output-enable for the pad's tristate buffer.

The sequencer counts serial clock edges to decide three things: when the analog input starts to be sampled, when hold begins, and when the converter gets a one-cycle start strobe. It drops the end-of-conversion flag at hold and raises it again when the converter reports done, capturing the new result at that moment. An asynchronous conversion-start pin can override the edge count: it stretches sampling for as long as it is held low, and it works while chip select is high.

The system clock must run at least four times faster than the serial clock. The captured command is presented as a plain output for the multiplexer and the mode decode.

Top module: `adc_serial_seq`

## Requirements
- R1: The interface mode is latched at each falling edge of `cs_n`. `fs` high selects microcontroller mode and `fs` low selects DSP mode. The mode selects the capture, output and control edges described in R2, R5 and R6.
- R2: The four command bits are captured MSB first and appear on `cmd` after the fourth bit. The capture edge is the rising `sclk` edge when the mode bit (microcontroller = 1) equals `inv_clk`, and the falling edge otherwise. In DSP mode, a falling edge of `fs` while `cs_n` is low restarts the frame counting.
- R3: After four command bits have been taken, `din` has no effect on `cmd` for the rest of the frame.
- R4: `dout_oe` is low while `cs_n` is high. After `cs_n` falls, `dout` shows bit 9 of the previous result, and the lower bits follow in descending order, one per output edge.
- R5: Output bits change on falling `sclk` edges in microcontroller mode and on rising edges in DSP mode, whatever the level of `inv_clk`.
- R6: `sample_en` rises at the fourth output edge. At the tenth control edge (the edge opposite the output edge) `conv_start` pulses for one cycle and `sample_en` falls.
- R7: `eoc` goes low together with `conv_start` and returns high in the cycle after `conv_done`. At that point `conv_result` becomes the new previous result.
- R8: From the tenth output edge onwards, `dout` is 0, so that transfers of 11 to 16 clocks end in zeros.
- R9: A falling edge of `cs_n` in the middle of a frame abandons it. Counters restart, `sample_en` clears, no conversion starts and the previous result is kept.
- R10: A falling edge of `cstart_n` sets `sample_en`. Its rising edge pulses `conv_start` and drops `eoc`. Both work while `cs_n` is high.
- R11: After reset, `eoc` is 1 and `dout_oe`, `sample_en`, `conv_start` and `cmd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| fs | input | 1 | Frame sync; its level at chip-select fall picks the mode |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command input |
| inv_clk | input | 1 | Capture-edge invert select |
| cstart_n | input | 1 | Asynchronous extended-sampling control |
| conv_done | input | 1 | Converter finished pulse |
| conv_result | input | 10 | Converter result, valid with conv_done |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Output enable for the dout pad |
| eoc | output | 1 | End of conversion, low while busy |
| sample_en | output | 1 | Sample switch control for the capacitor array |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| cmd | output | 4 | Captured command: channel and mode decode |

## Verification
The assertions check on every cycle that:
- `eoc` rises only after `conv_done`;
- a start strobe always comes with `eoc` low and sampling off;
- the command stays frozen once four bits are in;
- the tail of a frame drives zeros;
- `dout` shows the previous result's MSB as soon as it is enabled.

Only the bench scenarios can show the edge selection: which serial edge captures and which edge shifts in each mode and clock-invert setting. The bench shows this by moving `din` and reading `dout` between the two edges of every pulse. The bench scenarios also cover the cycle positions of sampling and hold, the result passed from one frame to the next, abort, and extended sampling with chip select high.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CMD_BITS    = 4;
  localparam int RES_BITS    = 10;
  localparam int SAMPLE_AT   = 4;
  localparam int HOLD_AT     = 10;
  localparam logic MODE_MCU  = 1'b1;
  localparam logic MODE_DSP  = 1'b0;
endpackage

// File: rtl/adc_seq_pin_sync.sv
module adc_seq_pin_sync #(
  parameter int N = 6,
  parameter int M = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [M-1:0] chg
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {2{RST_VAL[g]}};
      else        st <= {st[0], pin[g]};
    end
    assign lvl[g] = st[1];
    if (g < M) begin : g_edge
      logic prev;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RST_VAL[g];
        else        prev <= st[1];
      end
      assign chg[g] = st[1] ^ prev;
    end
  end
endmodule

// File: rtl/adc_seq_edge_sel.sv
module adc_seq_edge_sel (
  input  logic mode,
  input  logic inv,
  input  logic rise,
  input  logic fall,
  output logic in_edge,
  output logic out_edge,
  output logic ctrl_edge
);
  logic in_on_rise;
  always_comb begin
    in_on_rise = (mode == inv);
    in_edge    = in_on_rise ? rise : fall;
    out_edge   = mode ? fall : rise;
    ctrl_edge  = mode ? rise : fall;
  end
endmodule

// File: rtl/adc_seq_frame.sv
module adc_seq_frame #(
  parameter int CMD_W       = 4,
  parameter int RES_W       = 10,
  parameter int SAMPLE_EDGE = 4,
  parameter int HOLD_EDGE   = 10,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_lvl,
  input  logic             cs_fall,
  input  logic             fs_lvl,
  input  logic             fs_fall,
  input  logic             din_lvl,
  input  logic             in_edge,
  input  logic             out_edge,
  input  logic             ctrl_edge,
  input  logic [RES_W-1:0] res_q,
  output logic             mode,
  output logic             dout,
  output logic             dout_oe,
  output logic             samp_req,
  output logic             hold_req,
  output logic             abort,
  output logic [CMD_W-1:0] cmd,
  output logic [CNT_W-1:0] in_cnt,
  output logic [CNT_W-1:0] out_cnt
);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] CMAX   = '1;
  localparam logic [CNT_W-1:0] N_CMD  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] N_SAMP = CNT_W'(SAMPLE_EDGE - 1);
  localparam logic [CNT_W-1:0] N_HOLD = CNT_W'(HOLD_EDGE);

  logic             mode_q, mode_d, oe_q, oe_d, active, start;
  logic [CNT_W-1:0] in_q, in_d, out_q, out_d, ctl_q, ctl_d;
  logic [CMD_W-2:0] sh_q, sh_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic [RES_W-1:0] dsh_q, dsh_d;

  always_comb begin
    active = !cs_lvl;
    start  = cs_fall | (active & (mode_q == adc_seq_pkg::MODE_DSP) & fs_fall);
    mode_d = cs_fall ? fs_lvl : mode_q;
    oe_d   = active;
    in_d   = in_q;
    out_d  = out_q;
    ctl_d  = ctl_q;
    sh_d   = sh_q;
    cmd_d  = cmd_q;
    dsh_d  = dsh_q;
    if (start) begin
      in_d  = '0;
      out_d = '0;
      ctl_d = '0;
      dsh_d = res_q;
    end else if (active) begin
      if (in_edge && (in_q < N_CMD)) begin
        sh_d = {sh_q[CMD_W-3:0], din_lvl};
        in_d = in_q + ONE;
        if (in_q == N_CMD - ONE) cmd_d = {sh_q, din_lvl};
      end
      if (out_edge) begin
        dsh_d = {dsh_q[RES_W-2:0], 1'b0};
        if (out_q != CMAX) out_d = out_q + ONE;
      end
      if (ctrl_edge && (ctl_q < N_HOLD)) ctl_d = ctl_q + ONE;
    end
    samp_req = active & !start & out_edge & (out_q == N_SAMP);
    hold_req = active & !start & ctrl_edge & (ctl_q == N_HOLD - ONE);
    abort    = cs_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= adc_seq_pkg::MODE_MCU;
      oe_q   <= 1'b0;
      in_q   <= '0;
      out_q  <= '0;
      ctl_q  <= '0;
      sh_q   <= '0;
      cmd_q  <= '0;
      dsh_q  <= '0;
    end else begin
      mode_q <= mode_d;
      oe_q   <= oe_d;
      in_q   <= in_d;
      out_q  <= out_d;
      ctl_q  <= ctl_d;
      sh_q   <= sh_d;
      cmd_q  <= cmd_d;
      dsh_q  <= dsh_d;
    end
  end

  assign mode    = mode_q;
  assign dout_oe = oe_q;
  assign dout    = dsh_q[RES_W-1];
  assign cmd     = cmd_q;
  assign in_cnt  = in_q;
  assign out_cnt = out_q;
endmodule

// File: rtl/adc_seq_conv.sv
module adc_seq_conv #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_req,
  input  logic             hold_req,
  input  logic             abort,
  input  logic             cst_fall,
  input  logic             cst_rise,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             sample_en,
  output logic             conv_start,
  output logic             eoc,
  output logic [RES_W-1:0] res_q
);
  logic             samp_q, samp_d, start_q, start_d, eoc_q, eoc_d;
  logic [RES_W-1:0] res_r, res_d;

  always_comb begin
    samp_d  = samp_q;
    start_d = 1'b0;
    eoc_d   = eoc_q;
    res_d   = res_r;
    if (!eoc_q && conv_done) begin
      eoc_d = 1'b1;
      res_d = conv_result;
    end
    if (hold_req || cst_rise) begin
      start_d = 1'b1;
      samp_d  = 1'b0;
      eoc_d   = 1'b0;
    end else if (samp_req || cst_fall) begin
      samp_d = 1'b1;
    end else if (abort) begin
      samp_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= 1'b0;
      start_q <= 1'b0;
      eoc_q   <= 1'b1;
      res_r   <= '0;
    end else begin
      samp_q  <= samp_d;
      start_q <= start_d;
      eoc_q   <= eoc_d;
      res_r   <= res_d;
    end
  end

  assign sample_en  = samp_q;
  assign conv_start = start_q;
  assign eoc        = eoc_q;
  assign res_q      = res_r;
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq #(
  parameter int CMD_W       = adc_seq_pkg::CMD_BITS,
  parameter int RES_W       = adc_seq_pkg::RES_BITS,
  parameter int SAMPLE_EDGE = adc_seq_pkg::SAMPLE_AT,
  parameter int HOLD_EDGE   = adc_seq_pkg::HOLD_AT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             fs,
  input  logic             sclk,
  input  logic             din,
  input  logic             inv_clk,
  input  logic             cstart_n,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             dout,
  output logic             dout_oe,
  output logic             eoc,
  output logic             sample_en,
  output logic             conv_start,
  output logic [CMD_W-1:0] cmd
);
  localparam int CNT_W = $clog2(RES_W + HOLD_EDGE + 1);
  localparam int NPIN  = 6;
  localparam int NEDGE = 4;

  logic [1:0]       rst_pipe;
  logic             rst_s;
  logic [NPIN-1:0]  lvl;
  logic [NEDGE-1:0] chg;
  logic             cs_fall, fs_fall, sck_rise, sck_fall, cst_rise, cst_fall;
  logic             mode, in_edge, out_edge, ctrl_edge;
  logic             samp_req, hold_req, abort;
  logic [RES_W-1:0] res_q;
  logic [CNT_W-1:0] in_cnt, out_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  adc_seq_pin_sync #(.N(NPIN), .M(NEDGE), .RST_VAL(6'b101011)) u_sync (
    .clk(clk), .rst_n(rst_s),
    .pin({inv_clk, din, cstart_n, sclk, fs, cs_n}),
    .lvl(lvl), .chg(chg)
  );

  always_comb begin
    cs_fall  = chg[0] & !lvl[0];
    fs_fall  = chg[1] & !lvl[1];
    sck_rise = chg[2] &  lvl[2];
    sck_fall = chg[2] & !lvl[2];
    cst_fall = chg[3] & !lvl[3];
    cst_rise = chg[3] &  lvl[3];
  end

  adc_seq_edge_sel u_esel (
    .mode(mode), .inv(lvl[5]), .rise(sck_rise), .fall(sck_fall),
    .in_edge(in_edge), .out_edge(out_edge), .ctrl_edge(ctrl_edge)
  );

  adc_seq_frame #(.CMD_W(CMD_W), .RES_W(RES_W), .SAMPLE_EDGE(SAMPLE_EDGE),
                  .HOLD_EDGE(HOLD_EDGE), .CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_s), .cs_lvl(lvl[0]), .cs_fall(cs_fall),
    .fs_lvl(lvl[1]), .fs_fall(fs_fall), .din_lvl(lvl[4]),
    .in_edge(in_edge), .out_edge(out_edge), .ctrl_edge(ctrl_edge),
    .res_q(res_q), .mode(mode), .dout(dout), .dout_oe(dout_oe),
    .samp_req(samp_req), .hold_req(hold_req), .abort(abort),
    .cmd(cmd), .in_cnt(in_cnt), .out_cnt(out_cnt)
  );

  adc_seq_conv #(.RES_W(RES_W)) u_conv (
    .clk(clk), .rst_n(rst_s), .samp_req(samp_req), .hold_req(hold_req),
    .abort(abort), .cst_fall(cst_fall), .cst_rise(cst_rise),
    .conv_done(conv_done), .conv_result(conv_result),
    .sample_en(sample_en), .conv_start(conv_start), .eoc(eoc), .res_q(res_q)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CMD_W = 4,
  parameter int RES_W = 10,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eoc,
  input logic             conv_done,
  input logic             conv_start,
  input logic             sample_en,
  input logic             dout,
  input logic             dout_oe,
  input logic [CMD_W-1:0] cmd,
  input logic [RES_W-1:0] res_q,
  input logic [CNT_W-1:0] in_cnt,
  input logic [CNT_W-1:0] out_cnt
);
  AST_EOC_RISE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> $past(conv_done)); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !eoc); // R7
  AST_START_ENDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !sample_en); // R6
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt == CNT_W'(CMD_W)) && ($past(in_cnt) == CNT_W'(CMD_W)) |-> $stable(cmd)); // R3
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe && (out_cnt >= CNT_W'(RES_W)) |-> !dout); // R8
  AST_OE_SHOWS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> (dout == $past(res_q[RES_W-1]))); // R4
endmodule

bind adc_serial_seq adc_seq_chk #(.CMD_W(CMD_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_s), .eoc(eoc), .conv_done(conv_done),
  .conv_start(conv_start), .sample_en(sample_en), .dout(dout),
  .dout_oe(dout_oe), .cmd(cmd), .res_q(res_q), .in_cnt(in_cnt), .out_cnt(out_cnt)
);

// File: tb/sim_adc_serial_seq.sv
`timescale 1ns/1ps
module sim_adc_serial_seq;
  logic       clk = 1'b0;
  logic       rst_n, cs_n, fs, sclk, din, inv_clk, cstart_n, conv_done;
  logic [9:0] conv_result;
  logic       dout, dout_oe, eoc, sample_en, conv_start;
  logic [3:0] cmd;
  logic [9:0] next_res;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 0;

  always #2 clk = ~clk;

  adc_serial_seq u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs(fs), .sclk(sclk), .din(din),
    .inv_clk(inv_clk), .cstart_n(cstart_n), .conv_done(conv_done),
    .conv_result(conv_result), .dout(dout), .dout_oe(dout_oe), .eoc(eoc),
    .sample_en(sample_en), .conv_start(conv_start), .cmd(cmd)
  );

  // {fs level, inv_clk, command, result the converter will return}
  localparam logic [15:0] VEC [4] = '{
    {1'b1, 1'b1, 4'hA, 10'h2C5},
    {1'b1, 1'b0, 4'h3, 10'h1F0},
    {1'b0, 1'b1, 4'h5, 10'h3A9},
    {1'b0, 1'b0, 4'hC, 10'h055}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic fsv, input logic invv, input logic [3:0] c,
                       input int np, input logic [9:0] prev, input bit close);
    logic [15:0] exp_bits;
    logic        rise_in;
    exp_bits = {prev, 6'b0};
    rise_in  = (fsv == invv);
    fs = fsv; inv_clk = invv; sclk = 1'b0;
    wait_n(10);
    cs_n = 1'b0;
    wait_n(10);
    chk(dout_oe == 1'b1, "R4 oe", int'(dout_oe), 1);
    if (!fsv) begin
      fs = 1'b1; wait_n(10);
      fs = 1'b0; wait_n(10);
    end
    for (int i = 0; i < np; i++) begin
      logic bv;
      int   mid;
      bv = (i < 4) ? c[3-i] : ~c[i % 4];
      chk(dout == exp_bits[15-i], (i < 10) ? "R4 bit" : "R8 tail", int'(dout), int'(exp_bits[15-i]));
      din = rise_in ? bv : ~bv;
      wait_n(8); sclk = 1'b1; wait_n(8);
      mid = fsv ? i : i + 1;
      if (mid < 16)
        chk(dout == exp_bits[15-mid], (mid < 10) ? "R1/R5 mid" : "R8 mid", int'(dout), int'(exp_bits[15-mid]));
      din = rise_in ? ~bv : bv;
      wait_n(8); sclk = 1'b0; wait_n(8);
      if (i == 2) chk(sample_en == 1'b0, "R6 pre", int'(sample_en), 0);
      if (i == 3) chk(sample_en == 1'b1, "R6 sample", int'(sample_en), 1);
      if (i == 9) begin
        chk(eoc == 1'b0, "R7 busy", int'(eoc), 0);
        chk(sample_en == 1'b0, "R6 hold", int'(sample_en), 0);
      end
    end
    if (close) begin
      cs_n = 1'b1;
      wait_n(100);
      chk(eoc == 1'b1, "R7 done", int'(eoc), 1);
      chk(cmd == c, "R2/R3 cmd", int'(cmd), int'(c));
      chk(dout_oe == 1'b0, "R4 hiz", int'(dout_oe), 0);
    end
  endtask

  // Converter model: answers every start strobe after a fixed latency.
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        repeat (60) @(negedge clk);
        conv_result = next_res;
        conv_done   = 1'b1;
        @(negedge clk);
        conv_done   = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [9:0] prev;
    cs_n = 1'b1; fs = 1'b1; sclk = 1'b0; din = 1'b0; inv_clk = 1'b1;
    cstart_n = 1'b1; conv_done = 1'b0; conv_result = '0; next_res = '0;
    rst_n = 1'b0;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    // R11 reset state
    chk(eoc == 1'b1, "R11 eoc", int'(eoc), 1);
    chk(dout_oe == 1'b0, "R11 oe", int'(dout_oe), 0);
    chk(sample_en == 1'b0, "R11 sample", int'(sample_en), 0);
    chk(conv_start == 1'b0, "R11 start", int'(conv_start), 0);
    chk(cmd == 4'h0, "R11 cmd", int'(cmd), 0);

    prev = '0;
    for (int v = 0; v < 4; v++) begin
      next_res = VEC[v][9:0];
      frame(VEC[v][15], VEC[v][14], VEC[v][13:10], 16, prev, 1'b1);
      prev = next_res;
    end

    // R9 abort mid-frame after sampling has begun
    frame(1'b1, 1'b1, 4'h9, 5, prev, 1'b0);
    chk(sample_en == 1'b1, "R9 sampling", int'(sample_en), 1);
    cs_n = 1'b1; wait_n(10);
    cs_n = 1'b0; wait_n(10);
    chk(eoc == 1'b1, "R9 no conv", int'(eoc), 1);
    chk(sample_en == 1'b0, "R9 sample clr", int'(sample_en), 0);
    chk(dout == prev[9], "R9 msb kept", int'(dout), int'(prev[9]));
    cs_n = 1'b1; wait_n(10);
    next_res = 10'h1B3;
    frame(1'b1, 1'b1, 4'h6, 16, prev, 1'b1);
    prev = next_res;

    // R10 extended sampling with chip select high
    next_res = 10'h2E7;
    cstart_n = 1'b0; wait_n(10);
    chk(sample_en == 1'b1, "R10 sample", int'(sample_en), 1);
    chk(eoc == 1'b1, "R10 idle", int'(eoc), 1);
    cstart_n = 1'b1; wait_n(10);
    chk(eoc == 1'b0, "R10 busy", int'(eoc), 0);
    chk(sample_en == 1'b0, "R10 hold", int'(sample_en), 0);
    wait_n(100);
    chk(eoc == 1'b1, "R10 done", int'(eoc), 1);
    prev = next_res;
    next_res = 10'h0F0;
    frame(1'b1, 1'b0, 4'h1, 16, prev, 1'b1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule